// File: doc/BRIEF.md
# Ticket Lock Unit

A hardware lock server that grants fair, first-come first-served mutual exclusion to a fixed set of requesters. It holds two counters: the ticket that the next acquire will receive, and the ticket that currently owns the lock. An acquire atomically takes the next ticket and advances that counter. The winner is whichever requester's ticket equals the serving value. A release advances the serving value, which passes ownership to the next ticket in line.

Several acquires can arrive in the same cycle. They are ordered by a fixed priority, lowest index first, and each gets its own consecutive ticket. The unit reports how many tickets are outstanding. It also computes, for a queried ticket, how many owners remain ahead of it, so that a requester can pace its polling. A release made while nothing is outstanding is reported as an error and has no other effect.

Top module: `tkt_lock`

## Requirements
- R1: While rst_ni is low and after its release, serving_o is 0, depth_o is 0, busy_o is 0, gnt_o is 0 and rel_err_o is 0.
- R2: A request on acq_req_i[i] in a cycle raises gnt_o[i] for exactly the next cycle. The ticket in acq_ticket_o[i*TKT_W +: TKT_W] is then the value the next-ticket counter held at the request.
- R3: When several requests arrive in one cycle, the lowest index receives the current next-ticket value. Each higher requesting index receives the previous one plus one, and the next-ticket counter advances by the number of requests.
- R4: A release (rel_i high) while depth_o is nonzero increments serving_o by one, visible in the next cycle.
- R5: A release while depth_o is zero raises rel_err_o for the next cycle only and leaves serving_o unchanged.
- R6: depth_o equals (next-ticket minus serving_o) modulo 2^TKT_W. busy_o is 1 exactly when depth_o is nonzero.
- R7: wait_o equals (query_i minus serving_o) modulo 2^TKT_W, combinationally.
- R8: Both counters wrap from 2^TKT_W-1 to 0.
- R9: A cycle with no request leaves the next-ticket counter unchanged, and gnt_o is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acq_req_i | input | N_REQ | One acquire strobe per requester |
| gnt_o | output | N_REQ | Ticket-valid strobe per requester, one cycle after its request |
| acq_ticket_o | output | N_REQ*TKT_W | Ticket per requester, field i at [i*TKT_W +: TKT_W] |
| rel_i | input | 1 | Release strobe from the current owner |
| serving_o | output | TKT_W | Ticket that currently owns the lock |
| query_i | input | TKT_W | Ticket whose wait distance is asked for |
| wait_o | output | TKT_W | Owners ahead of query_i |
| depth_o | output | TKT_W | Outstanding tickets |
| busy_o | output | 1 | Lock held or queued |
| rel_err_o | output | 1 | Release with nothing outstanding |

## Verification
The bench builds the unit with N_REQ=3 and TKT_W=3. With these values every one of the eight request patterns can be applied together with and without a release, and from many counter positions. The counters wrap many times within a short run. Releases on an empty queue and requests that fill the queue to seven outstanding tickets both come up often, which covers the boundaries of the modulo arithmetic.

// File: rtl/tkt_pkg.sv
package tkt_pkg;
  typedef enum logic [1:0] {
    REL_NONE = 2'd0,
    REL_OK   = 2'd1,
    REL_BAD  = 2'd2
  } rel_kind_e;
endpackage

// File: rtl/tkt_alloc.sv
module tkt_alloc #(
  parameter int N_REQ = 4,
  parameter int TKT_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_REQ-1:0]             req_i,
  output logic [TKT_W-1:0]             next_o,
  output logic [N_REQ-1:0]             gnt_o,
  output logic [N_REQ-1:0][TKT_W-1:0]  ticket_o
);
  // prefix count of requests below each index, modulo 2^TKT_W
  logic [N_REQ:0][TKT_W-1:0] pre;
  logic [TKT_W-1:0]          next_q;
  logic [N_REQ-1:0]          gnt_q;
  logic [N_REQ-1:0][TKT_W-1:0] tkt_q;

  for (genvar g = 0; g <= N_REQ; g++) begin : g_pre
    if (g == 0) begin : g_base
      assign pre[g] = '0;
    end else begin : g_step
      assign pre[g] = pre[g-1] + TKT_W'(req_i[g-1]);
    end
  end

  for (genvar g = 0; g < N_REQ; g++) begin : g_tkt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tkt_q[g] <= '0;
      else if (req_i[g]) tkt_q[g] <= next_q + pre[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= '0;
      gnt_q  <= '0;
    end else begin
      next_q <= next_q + pre[N_REQ];
      gnt_q  <= req_i;
    end
  end

  assign next_o   = next_q;
  assign gnt_o    = gnt_q;
  assign ticket_o = tkt_q;

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> $stable(next_q));
  p_low_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |=> (tkt_q[0] == $past(next_q)) && gnt_q[0]);
  p_gnt_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> (gnt_q == '0));
endmodule

// File: rtl/tkt_owner.sv
module tkt_owner
  import tkt_pkg::*;
#(
  parameter int TKT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rel_i,
  input  logic [TKT_W-1:0] depth_i,
  output logic [TKT_W-1:0] serving_o,
  output logic             rel_err_o
);
  rel_kind_e        kind;
  logic [TKT_W-1:0] serving_q;
  logic             err_q;

  always_comb begin
    kind = REL_NONE;
    if (rel_i) kind = (depth_i != '0) ? REL_OK : REL_BAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serving_q <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= (kind == REL_BAD);
      if (kind == REL_OK) serving_q <= serving_q + 1'b1;
    end
  end

  assign serving_o = serving_q;
  assign rel_err_o = err_q;

  p_bad_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && depth_i == '0) |=> (err_q && $stable(serving_q)));
  p_no_release_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_i |=> ($stable(serving_q) && !err_q));
endmodule

// File: rtl/tkt_lock.sv
module tkt_lock #(
  parameter int N_REQ = 4,
  parameter int TKT_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_REQ-1:0]         acq_req_i,
  output logic [N_REQ-1:0]         gnt_o,
  output logic [N_REQ*TKT_W-1:0]   acq_ticket_o,
  input  logic                     rel_i,
  output logic [TKT_W-1:0]         serving_o,
  input  logic [TKT_W-1:0]         query_i,
  output logic [TKT_W-1:0]         wait_o,
  output logic [TKT_W-1:0]         depth_o,
  output logic                     busy_o,
  output logic                     rel_err_o
);
  logic [TKT_W-1:0]            next_w;
  logic [TKT_W-1:0]            serv_w;
  logic [TKT_W-1:0]            depth_w;
  logic [N_REQ-1:0][TKT_W-1:0] tkt_w;

  tkt_alloc #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_alloc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (acq_req_i),
    .next_o   (next_w),
    .gnt_o    (gnt_o),
    .ticket_o (tkt_w)
  );

  assign depth_w = next_w - serv_w;

  tkt_owner #(.TKT_W(TKT_W)) u_owner (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rel_i     (rel_i),
    .depth_i   (depth_w),
    .serving_o (serv_w),
    .rel_err_o (rel_err_o)
  );

  assign acq_ticket_o = tkt_w;
  assign serving_o    = serv_w;
  assign depth_o      = depth_w;
  assign busy_o       = (depth_w != '0);
  assign wait_o       = query_i - serv_w;

  p_release_shrinks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && busy_o && acq_req_i == '0) |=> (depth_o == $past(depth_o) - 1'b1));
  p_idle_depth_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rel_i && acq_req_i == '0) |=> $stable(depth_o));
endmodule

// File: tb/tkt_lock_bench.sv
module tkt_lock_bench;
  localparam int N = 3;
  localparam int W = 3;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   req = '0;
  logic [N-1:0]   gnt;
  logic [N*W-1:0] tkt;
  logic           rel = 1'b0;
  logic [W-1:0]   serving, query = '0, wait_v, depth;
  logic           busy, rel_err;

  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  tkt_lock #(.N_REQ(N), .TKT_W(W)) u_tkt_lock (
    .clk_i(clk), .rst_ni(rst_n), .acq_req_i(req), .gnt_o(gnt),
    .acq_ticket_o(tkt), .rel_i(rel), .serving_o(serving), .query_i(query),
    .wait_o(wait_v), .depth_o(depth), .busy_o(busy), .rel_err_o(rel_err)
  );

  task automatic chk(input string req_tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int nxt = 0, srv = 0;
    #1;
    // R1 during reset
    chk("R1 serving in reset", int'(serving), 0);
    chk("R1 depth in reset", int'(depth), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 serving", int'(serving), 0);
    chk("R1 depth", int'(depth), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 gnt", int'(gnt), 0);
    chk("R1 rel_err", int'(rel_err), 0);

    for (int i = 0; i < 2048; i++) begin
      int pat, pop, dep, e_err, run;
      pat = i % 8;
      rel = ((i / 8) % 3) != 0 ? 1'b0 : 1'b1;
      if ((i / 256) % 2 == 1) rel = ~rel;
      query = W'((i * 5) % M);
      pop = 0;
      for (int b = 0; b < N; b++) pop += (pat >> b) & 1;
      dep = (nxt - srv + M) % M;
      if (dep + pop > M - 1) pat = 0;
      pop = 0;
      for (int b = 0; b < N; b++) pop += (pat >> b) & 1;
      req = N'(pat);
      #1;
      chk("R6 depth", int'(depth), dep);
      chk("R6 busy", int'(busy), dep != 0 ? 1 : 0);
      chk("R7 wait", int'(wait_v), (int'(query) - srv + M) % M);
      e_err = (rel && dep == 0) ? 1 : 0;
      if (rel && dep != 0) srv = (srv + 1) % M; // R4 / R8 wrap
      @(posedge clk);
      #1;
      chk(pat == 0 ? "R9 gnt idle" : "R2 gnt", int'(gnt), pat);
      run = nxt;
      for (int b = 0; b < N; b++) begin
        if ((pat >> b) & 1) begin
          chk("R3 ticket order", int'(tkt[b*W +: W]), run);
          run = (run + 1) % M;
        end
      end
      nxt = run; // R8 wrap via modulo
      chk("R4 serving", int'(serving), srv);
      chk("R5 rel_err", int'(rel_err), e_err);
      @(negedge clk);
    end

    req = '0;
    rel = 1'b0;
    @(posedge clk);
    #1;
    chk("R5 rel_err clears", int'(rel_err), 0);
    chk("R9 gnt clears", int'(gnt), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule